// File: doc/BRIEF.md
# Register-Access I2C Target

This block is an I2C target that gives a bus master access to ten 8-bit configuration registers. SCL and SDA are sampled with the system clock. Each line passes through a two-flop synchronizer and a persistence filter. The filtered lines feed a detector that finds SCL edges and START, repeated START and STOP conditions. A byte-level state machine then matches the fixed 7-bit device address and acknowledges bytes. It loads an internal register pointer and moves register contents in or out one byte at a time, and the pointer steps forward after every data byte.

A write frame has three parts: the address byte, a pointer byte, and then any number of data bytes. A random read is a write frame that carries only the pointer byte, followed by a repeated START and the read address. Every register is always visible on a flat output bus, which the surrounding logic uses directly as configuration. SDA is driven open-drain: the block only asks for the line to be pulled low or released. The block has no stream interface. The serial bus is its only data path, and the register bus is a plain level output with no handshake and no back-pressure.

Top module: `i2c_reg_target`

## Requirements
- R1: The device address is 7'b1001101. A START followed by byte 0x9A (LSB 0) opens a write frame, and 0x9B (LSB 1) opens a read frame. Both address bytes are acknowledged.
- R2: An address byte with any other upper seven bits is not acknowledged. The block then acknowledges nothing and writes nothing until the next START, even if a later byte equals 0x9A.
- R3: After each accepted address, pointer or data byte, the block keeps SDA low for the entire ninth SCL high phase. It changes its SDA drive only while SCL is low.
- R4: In a write frame, the first byte after the address is acknowledged and loaded into the register pointer.
- R5: Each following data byte is written to the register the pointer selects, and then the pointer increments by one. Register i is presented on regs_o[8*i+7:8*i].
- R6: A data byte whose pointer is above 0x09 is acknowledged but changes no register.
- R7: A read frame sends the register at the current pointer, MSB first, and increments the pointer after each byte sent. Pointers above 0x09 read as 0x00.
- R8: When the master answers a read byte with a not-acknowledge (SDA high), the block releases SDA and stays silent until the next START.
- R9: A STOP ends the frame at any point, including in the middle of a byte. A partial byte is then discarded. A STOP that rises in the same SCL high phase as the START before it is ignored.
- R10: A repeated START restarts the address phase without a STOP, so a pointer-only write followed by a read address gives a random read.
- R11: After reset, all registers read 0x00, the pointer is 0x00 and SDA is released.
- R12: A pulse on SCL shorter than FILT_LEN system clocks is not counted as a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired bus value) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | NUM_REGS*8 | All configuration registers, register i at bits 8*i+7:8*i |

## Verification
The bench samples SDA on every system clock of each ninth pulse. A design that acknowledges late, or releases the line early, therefore shows up even if the acknowledge is right at mid-pulse. A STOP that rises in the same high phase as its START must be ignored. A design that honours it drops the address and loses the write that follows. A STOP sent after three data bits must discard the partial byte and leave the next START-plus-address accepted; a design that commits the byte or stays out of step fails both checks. Other cases: reserved pointers, where a design writes a neighbour or returns stale data; a NACK followed by extra clocks, where a design keeps transmitting; and a two-clock SCL spike, where an unfiltered design shifts in a spurious bit and corrupts the stored byte.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_SKIP
  } tgt_state_t;

  typedef enum logic [1:0] {
    BY_ADDR,
    BY_PTR,
    BY_DATA
  } byte_kind_t;
endpackage

// File: rtl/i2c_line_filter.sv
// Two-flop synchronizer followed by a persistence filter: the output
// follows the input only after FILT_LEN consecutive differing samples.
module i2c_line_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == line_o) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        line_o <= sync_q[1];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/i2c_bus_events.sv
// Edge and bus-condition detector on the filtered lines.
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q, start_in_high_q;
  logic stop_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q           <= 1'b1;
      sda_q           <= 1'b1;
      start_in_high_q <= 1'b0;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
      if (scl_fall)       start_in_high_q <= 1'b0;
      else if (start_evt) start_in_high_q <= 1'b1;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_evt = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_raw  = scl_f & scl_q & ~sda_q & sda_f;
  // a STOP inside the same high phase as a START does not count
  assign stop_evt  = stop_raw & ~start_in_high_q;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int NUM_REGS = 10,
  parameter int DW       = 8,
  parameter int AW       = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic [AW-1:0]          rd_addr,
  output logic [DW-1:0]          rd_data,
  output logic [NUM_REGS*DW-1:0] regs_o
);
  logic [DW-1:0] mem [NUM_REGS];

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             mem[gi] <= '0;
      else if (wr_en && wr_addr == AW'(gi))   mem[gi] <= wr_data;
    end
    assign regs_o[gi*DW +: DW] = mem[gi];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_addr == AW'(i)) rd_data = mem[i];
    end
  end
endmodule

// File: rtl/i2c_target_fsm.sv
// Byte-level protocol engine: address match, pointer load, data in/out.
module i2c_target_fsm
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1001101,
  parameter int         NUM_REGS = 10,
  parameter int         AW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_f,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] ptr_o,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          sda_oe,
  output logic          skip_o
);
  tgt_state_t    state_q;
  byte_kind_t    kind_q;
  logic [3:0]    bitcnt_q;
  logic [7:0]    shreg_q;
  logic [7:0]    txreg_q;
  logic          rw_q;
  logic          mack_q;
  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      kind_q   <= BY_ADDR;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      txreg_q  <= '0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b1;
      ptr_q    <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_evt) begin
        state_q  <= ST_RX;
        kind_q   <= BY_ADDR;
        bitcnt_q <= '0;
        rw_q     <= 1'b0;
      end else if (stop_evt) begin
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_RX: begin
            if (scl_rise && bitcnt_q != 4'd8) begin
              shreg_q  <= {shreg_q[6:0], sda_f};
              bitcnt_q <= bitcnt_q + 4'd1;
            end else if (scl_fall && bitcnt_q == 4'd8) begin
              bitcnt_q <= '0;
              unique case (kind_q)
                BY_ADDR: begin
                  if (shreg_q[7:1] == DEV_ADDR) begin
                    rw_q    <= shreg_q[0];
                    kind_q  <= BY_PTR;
                    state_q <= ST_ACK;
                  end else begin
                    state_q <= ST_SKIP;
                  end
                end
                BY_PTR: begin
                  ptr_q   <= AW'(shreg_q);
                  kind_q  <= BY_DATA;
                  state_q <= ST_ACK;
                end
                default: begin
                  if (ptr_q < AW'(NUM_REGS)) begin
                    wr_en   <= 1'b1;
                    wr_addr <= ptr_q;
                    wr_data <= shreg_q;
                  end
                  ptr_q   <= ptr_q + AW'(1);
                  state_q <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (rw_q) begin
                txreg_q  <= rd_data;
                ptr_q    <= ptr_q + AW'(1);
                bitcnt_q <= '0;
                state_q  <= ST_TX;
              end else begin
                state_q <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt_q == 4'd7) begin
                state_q <= ST_MACK;
              end else begin
                txreg_q  <= {txreg_q[6:0], 1'b0};
                bitcnt_q <= bitcnt_q + 4'd1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_q <= sda_f;
            end else if (scl_fall) begin
              if (!mack_q) begin
                txreg_q  <= rd_data;
                ptr_q    <= ptr_q + AW'(1);
                bitcnt_q <= '0;
                state_q  <= ST_TX;
              end else begin
                state_q <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe = (state_q == ST_ACK) || (state_q == ST_TX && !txreg_q[7]);
  assign skip_o = (state_q == ST_SKIP);
  assign ptr_o  = ptr_q;
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter logic [6:0] DEV_ADDR = 7'b1001101,
  parameter int         NUM_REGS = 10,
  parameter int         FILT_LEN = 4,
  parameter int         AW       = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, filt_lines;
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_evt, stop_evt;
  logic [AW-1:0] ptr, wr_addr;
  logic [7:0] wr_data, rd_data;
  logic wr_en, fsm_skip;

  assign raw_lines = {sda_i, scl_i};

  for (genvar gl = 0; gl < NLINES; gl++) begin : g_filt
    i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .line_i(raw_lines[gl]), .line_o(filt_lines[gl])
    );
  end

  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  i2c_bus_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_target_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_f(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .rd_data(rd_data), .ptr_o(ptr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sda_oe(sda_oe), .skip_o(fsm_skip)
  );

  i2c_reg_bank #(.NUM_REGS(NUM_REGS), .DW(8), .AW(AW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(ptr), .rd_data(rd_data), .regs_o(regs_o)
  );
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk #(
  parameter int NUM_REGS = 10,
  parameter int AW       = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_f,
  input logic          sda_oe,
  input logic          stop_evt,
  input logic          in_skip,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] ptr
);
  // R3: drive changes only while SCL is low
  a_r3_drive_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && $past(scl_f)) |-> $stable(sda_oe));

  // R9: a recognised STOP leaves SDA released
  a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  // R6: no register write for a reserved pointer
  a_r6_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr < AW'(NUM_REGS)));

  // R5: pointer has moved one past the written register
  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (ptr == wr_addr + AW'(1)));

  // R2: while ignoring the bus, no drive and no write
  a_r2_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_skip |-> (!sda_oe && !wr_en));
endmodule

bind i2c_reg_target i2c_reg_target_chk #(.NUM_REGS(NUM_REGS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_oe(sda_oe),
  .stop_evt(stop_evt), .in_skip(fsm_skip), .wr_en(wr_en),
  .wr_addr(wr_addr), .ptr(ptr)
);

// File: tb/i2c_reg_target_bench.sv
module i2c_reg_target_bench;
  localparam int Q = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic [79:0] regs;
  wire sda_bus = m_sda & ~sda_oe;

  i2c_reg_target u_i2c_reg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .regs_o(regs)
  );

  int n_chk = 0;
  int n_fail = 0;

  // {pointer, written data, expected readback}
  localparam logic [23:0] VEC [8] = '{
    {8'h00, 8'h11, 8'h11}, {8'h09, 8'hA5, 8'hA5}, {8'h03, 8'h3C, 8'h3C},
    {8'h0A, 8'h77, 8'h00}, {8'hFF, 8'h55, 8'h00}, {8'h05, 8'hFF, 8'hFF},
    {8'h05, 8'h00, 8'h00}, {8'h07, 8'h80, 8'h80}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits, input bit glitch);
    for (int i = 7; i > 7 - nbits; i--) begin
      m_sda = b[i];
      if (glitch) begin
        tick(Q/2); m_scl = 1'b1; tick(2); m_scl = 1'b0; tick(Q/2 - 2);
      end else begin
        tick(Q);
      end
      m_scl = 1'b1; tick(2*Q);
      m_scl = 1'b0; tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
    send_bits(b, 8, glitch);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1;
    acked = 1'b1;
    for (int k = 0; k < 2*Q; k++) begin
      tick(1);
      if (sda_bus !== 1'b0) acked = 1'b0;
    end
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit nack);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); m_scl = 1'b1;
      tick(Q); b[i] = sda_bus;
      tick(Q); m_scl = 1'b0;
      tick(Q);
    end
    m_sda = nack; tick(Q);
    m_scl = 1'b1; tick(2*Q);
    m_scl = 1'b0; tick(Q);
    m_sda = 1'b1;
  endtask

  task automatic write_one(input logic [7:0] p, input logic [7:0] d, input string tag);
    bit a;
    bus_start;
    send_byte(8'h9A, 1'b0, a); check({tag, " R1 write address ack"}, a, 1);
    send_byte(p, 1'b0, a);     check({tag, " R4 pointer ack"}, a, 1);
    send_byte(d, 1'b0, a);     check({tag, " R3 data ack"}, a, 1);
    bus_stop;
  endtask

  task automatic read_at(input logic [7:0] p, output logic [7:0] b);
    bit a;
    bus_start;
    send_byte(8'h9A, 1'b0, a);
    send_byte(p, 1'b0, a);
    bus_start;                  // repeated START, R10
    send_byte(8'h9B, 1'b0, a); check("R10 read address ack after repeated START", a, 1);
    recv_byte(b, 1'b1);
    bus_stop;
  endtask

  initial begin
    bit a;
    logic [7:0] b;

    // R11: reset state
    tick(5);
    check("R11 regs in reset", regs, 80'h0);
    check("R11 sda released in reset", sda_oe, 0);
    rst_n = 1'b1;
    tick(10);
    check("R11 regs after reset", regs, 80'h0);
    check("R11 sda released after reset", sda_oe, 0);

    // table walk: R5, R6, R7
    for (int v = 0; v < 8; v++) begin
      write_one(VEC[v][23:16], VEC[v][15:8], "vec");
      read_at(VEC[v][23:16], b);
      check("R7 R6 readback", b, VEC[v][7:0]);
      if (VEC[v][23:16] < 8'h0A)
        check("R5 register port", regs[VEC[v][23:16]*8 +: 8], VEC[v][7:0]);
    end
    check("R6 reserved writes left other regs", regs,
          {8'hA5, 8'h00, 8'h80, 8'h00, 8'h00, 8'h00, 8'h3C, 8'h00, 8'h00, 8'h11});

    // R5: burst write with auto-increment
    bus_start;
    send_byte(8'h9A, 1'b0, a);
    send_byte(8'h01, 1'b0, a);
    send_byte(8'hA1, 1'b0, a); check("R5 burst byte 1 ack", a, 1);
    send_byte(8'hA2, 1'b0, a); check("R5 burst byte 2 ack", a, 1);
    send_byte(8'hA3, 1'b0, a); check("R5 burst byte 3 ack", a, 1);
    bus_stop;
    check("R5 burst result", regs[31:8], 24'hA3A2A1);

    // R7: sequential read, then read at current pointer (now 3)
    bus_start;
    send_byte(8'h9A, 1'b0, a);
    send_byte(8'h01, 1'b0, a);
    bus_start;
    send_byte(8'h9B, 1'b0, a); check("R1 read address ack", a, 1);
    recv_byte(b, 1'b0); check("R7 sequential byte 1", b, 8'hA1);
    recv_byte(b, 1'b1); check("R7 sequential byte 2", b, 8'hA2);
    bus_stop;
    bus_start;
    send_byte(8'h9B, 1'b0, a);
    recv_byte(b, 1'b1); check("R7 read at current pointer", b, 8'hA3);
    // R8: after NACK the target stays silent (next reg 4 holds 0x00)
    check("R8 sda released after NACK", sda_oe, 0);
    recv_byte(b, 1'b1); check("R8 no data after NACK", b, 8'hFF);
    bus_stop;

    // R2: address mismatch, then ignored bytes
    bus_start;
    send_byte(8'h9C, 1'b0, a); check("R2 wrong address not acked", a, 0);
    send_byte(8'h9A, 1'b0, a); check("R2 ignored until START", a, 0);
    send_byte(8'h07, 1'b0, a); check("R2 later byte not acked", a, 0);
    bus_stop;
    check("R2 reg 7 unchanged", regs[63:56], 8'h80);

    // R9: STOP in the middle of a data byte
    bus_start;
    send_byte(8'h9A, 1'b0, a);
    send_byte(8'h06, 1'b0, a);
    send_bits(8'hC3, 3, 1'b0);
    bus_stop;
    check("R9 partial byte discarded", regs[55:48], 8'h00);
    bus_start;
    send_byte(8'h9A, 1'b0, a); check("R9 address accepted after early STOP", a, 1);
    bus_stop;

    // R9: STOP within the START's high phase is ignored
    m_sda = 1'b1; m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b0; tick(Q);
    send_byte(8'h9A, 1'b0, a); check("R9 STOP in START phase ignored", a, 1);
    send_byte(8'h06, 1'b0, a);
    send_byte(8'h6B, 1'b0, a);
    bus_stop;
    check("R9 write after ignored STOP", regs[55:48], 8'h6B);

    // R12: short SCL spikes during a data byte
    bus_start;
    send_byte(8'h9A, 1'b0, a);
    send_byte(8'h04, 1'b0, a);
    send_byte(8'h5A, 1'b1, a); check("R12 ack with spikes", a, 1);
    bus_stop;
    check("R12 spikes filtered", regs[39:32], 8'h5A);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule